// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block sits on the host side of a byte-wide parallel programming port of a target microcontroller. It takes one command at a time on a valid/ready handshake. A load command carries an address low byte and a 16-bit word. A read command carries an address low byte only. The block then drives the pins that perform the command on the target: a strobe clock, a two-bit action code, a byte select, a page-latch pulse, an active-low output enable and the 8-bit data bus with its own drive enable.

A load makes three strobes: address, data low byte, data high byte. A page-latch pulse then moves the word into the target's page buffer. A read makes one address strobe. It then lowers the output enable and samples the low byte and then the high byte. It raises the output enable again, waits for the target to release the bus, and returns the 16-bit result with a one-cycle valid pulse.

Every timing limit is a parameter in nanoseconds. Each one is turned into whole clock cycles by rounding up against a clock-period parameter.

Top module: `pprog_seq`

## Requirements
- R1: A load drives three strobes in this order: action code 2'b00 with the address byte on the bus, then action code 2'b01 with data bits [7:0], then action code 2'b01 with data bits [15:8]. The action code is 2'b00 whenever the block is idle.
- R2: Byte select is 0 for the address strobe, the data-low strobe and the low-byte read. It is 1 for the data-high strobe, the page-latch phase and the high-byte read.
- R3: Bus, action code and byte select are stable for SU cycles before each strobe rise. The strobe is high for HI cycles and held low for HO cycles afterwards. The low time between two strobes of one command is at least LH cycles.
- R4: After the third load strobe falls and its hold ends, the page-latch output rises PLD cycles later. It stays high for PLW cycles, and the command ends when it falls.
- R5: A read makes one address strobe (code 2'b00) and then holds output enable low. Byte select is 0 for DV cycles and then 1 for DV cycles. Output enable then returns high for RZ cycles before the command ends.
- R6: The block never drives the bus while output enable is low. The drive enable is 0 during the whole output-enable window and during the release window after it.
- R7: rd_valid is a single-cycle pulse in the last release cycle. rd_data is {high byte, low byte}, each byte sampled in the last cycle of its own DV window.
- R8: busy is high from the cycle after acceptance to the end of the command, and cmd_ready is its inverse. cmd_valid has no effect while busy is high, whatever the command fields hold.
- R9: During and after reset the strobe and page latch are low, output enable is high, drive enable is 0, busy and rd_valid are 0 and the action code is 2'b00.
- R10: Each limit in cycles is ceil(ns*1000/CLK_PS), with a minimum of 1. SU is the larger of the setup count and (LH - HO).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_rd | input | 1 | 1 = read word, 0 = load word |
| cmd_addr | input | 8 | Address low byte |
| cmd_wdata | input | 16 | Word to load |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 16 | Read result |
| tgt_strobe | output | 1 | Strobe clock to the target |
| tgt_act | output | 2 | Action code |
| tgt_bsel | output | 1 | Byte select |
| tgt_latch | output | 1 | Page-latch pulse |
| tgt_oe_n | output | 1 | Target output enable, active low |
| tgt_dout | output | 8 | Bus value driven by the host |
| tgt_dout_en | output | 1 | Host bus drive enable |
| tgt_din | input | 8 | Bus value read from the target |

## Verification
A wrong state or a wrong timer load changes a pin in the very cycle it happens. Every output is decoded straight from the state and the step index, so a skipped or stretched phase shifts a strobe edge, a byte-select change or the page-latch pulse by at least one cycle. The per-clock reference comparison catches that shift at once. A wrong sample point or a byte swap in the capture path is seen only in rd_data during the one cycle rd_valid is high, at the end of the read. Any clash on the bus shows as drive enable high while output enable is low, in the first cycle it occurs.

// File: rtl/pprog_pkg.sv
// Shared types and helpers for the parallel programming sequencer.
// Assumes integer nanosecond limits and a clock period given in picoseconds.
package pprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_HOLD,
        ST_PL_WAIT,
        ST_PL_HIGH,
        ST_OE_LO,
        ST_OE_HI,
        ST_RELEASE
    } seq_state_e;

    localparam logic [1:0] ACT_ADDR = 2'b00;
    localparam logic [1:0] ACT_DATA = 2'b01;

    // Round a nanosecond limit up to whole clock cycles, at least one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned ps);
        int unsigned c;
        c = (ns * 1000 + ps - 1) / ps;
        return (c == 0) ? 1 : c;
    endfunction

    // Larger of two unsigned values.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pprog_timer.sv
// Phase timer: loaded with (length - 1) when a phase begins, counts down to zero.
// Assumes the controller reloads it on each phase change.
module pprog_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    // Count down toward zero, or take a new phase length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pprog_lane.sv
// Pin decoder: turns the sequencer state and byte step into the target pin levels.
// Assumes step 0/1/2 select address, data low and data high during a load.
module pprog_lane
    import pprog_pkg::*;
(
    input  seq_state_e  state,
    input  logic [1:0]  step,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    output logic        strobe,
    output logic [1:0]  act,
    output logic        bsel,
    output logic        latch,
    output logic        oe_n,
    output logic [7:0]  dout,
    output logic        dout_en
);
    logic load_phase;
    logic oe_phase;

    // Phases in which the host owns the bus.
    always_comb begin
        load_phase = (state == ST_SETUP) || (state == ST_HIGH) || (state == ST_HOLD) ||
                     (state == ST_PL_WAIT) || (state == ST_PL_HIGH);
        oe_phase   = (state == ST_OE_LO) || (state == ST_OE_HI);
    end

    // Byte placed on the bus for the current step.
    always_comb begin
        case (step)
            2'd0:    dout = addr;
            2'd1:    dout = wdata[7:0];
            default: dout = wdata[15:8];
        endcase
    end

    // Control pin levels.
    always_comb begin
        strobe  = (state == ST_HIGH);
        act     = (load_phase && step != 2'd0) ? ACT_DATA : ACT_ADDR;
        bsel    = (load_phase && step == 2'd2) || (state == ST_OE_HI);
        latch   = (state == ST_PL_HIGH);
        oe_n    = !oe_phase;
        dout_en = load_phase;
    end
endmodule

// File: rtl/pprog_capture.sv
// Read capture: holds the two bytes sampled from the target bus.
// Assumes each capture strobe comes at the end of its data-valid window.
module pprog_capture (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_lo,
    input  logic        cap_hi,
    input  logic [7:0]  din,
    output logic [15:0] word
);
    logic [7:0] lo_q;
    logic [7:0] hi_q;

    // Sample each byte when told to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= din;
            if (cap_hi) hi_q <= din;
        end
    end

    assign word = {hi_q, lo_q};
endmodule

// File: rtl/pprog_seq.sv
// Parallel programming sequencer top. It accepts load/read word commands and
// runs the matching strobe, page-latch and output-enable sequence. Every
// timing limit is a nanosecond parameter, rounded up to clock cycles.
// Assumes a single target and one command in flight at a time.
module pprog_seq
    import pprog_pkg::*;
#(
    parameter int unsigned CLK_PS      = 5000,
    parameter int unsigned T_SETUP_NS  = 67,
    parameter int unsigned T_HIGH_NS   = 150,
    parameter int unsigned T_LOW_NS    = 200,
    parameter int unsigned T_HOLD_NS   = 0,
    parameter int unsigned T_PL_DLY_NS = 67,
    parameter int unsigned T_PL_WID_NS = 150,
    parameter int unsigned T_DV_NS     = 250,
    parameter int unsigned T_REL_NS    = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_rd,
    input  logic [7:0]  cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        rd_valid,
    output logic [15:0] rd_data,
    output logic        tgt_strobe,
    output logic [1:0]  tgt_act,
    output logic        tgt_bsel,
    output logic        tgt_latch,
    output logic        tgt_oe_n,
    output logic [7:0]  tgt_dout,
    output logic        tgt_dout_en,
    input  logic [7:0]  tgt_din
);
    localparam int unsigned HO_CYC  = ns_to_cyc(T_HOLD_NS, CLK_PS);
    localparam int unsigned HI_CYC  = ns_to_cyc(T_HIGH_NS, CLK_PS);
    localparam int unsigned LH_CYC  = ns_to_cyc(T_LOW_NS, CLK_PS);
    localparam int unsigned SU_CYC  = max_u(ns_to_cyc(T_SETUP_NS, CLK_PS),
                                            (LH_CYC > HO_CYC) ? LH_CYC - HO_CYC : 1);
    localparam int unsigned PLD_CYC = ns_to_cyc(T_PL_DLY_NS, CLK_PS);
    localparam int unsigned PLW_CYC = ns_to_cyc(T_PL_WID_NS, CLK_PS);
    localparam int unsigned DV_CYC  = ns_to_cyc(T_DV_NS, CLK_PS);
    localparam int unsigned RZ_CYC  = ns_to_cyc(T_REL_NS, CLK_PS);
    localparam int unsigned MAX_CYC = max_u(max_u(max_u(SU_CYC, HI_CYC), max_u(HO_CYC, PLD_CYC)),
                                            max_u(max_u(PLW_CYC, DV_CYC), RZ_CYC));
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    seq_state_e    state_q, state_d;
    logic [1:0]    step_q, step_d;
    logic          rd_q;
    logic [7:0]    addr_q;
    logic [15:0]   wdata_q;
    logic          accept;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          cap_lo;
    logic          cap_hi;

    assign accept    = (state_q == ST_IDLE) && cmd_valid;
    assign busy      = (state_q != ST_IDLE);
    assign cmd_ready = !busy;
    assign rd_valid  = (state_q == ST_RELEASE) && tmr_zero;

    // Next-state and phase-length selection.
    always_comb begin
        state_d  = state_q;
        step_d   = step_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        case (state_q)
            ST_IDLE: if (cmd_valid) begin
                state_d  = ST_SETUP;
                step_d   = 2'd0;
                tmr_load = 1'b1;
                tmr_val  = CW'(SU_CYC - 1);
            end
            ST_SETUP: if (tmr_zero) begin
                state_d  = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CW'(HI_CYC - 1);
            end
            ST_HIGH: if (tmr_zero) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CW'(HO_CYC - 1);
            end
            ST_HOLD: if (tmr_zero) begin
                tmr_load = 1'b1;
                if (rd_q) begin
                    state_d = ST_OE_LO;
                    tmr_val = CW'(DV_CYC - 1);
                end else if (step_q == 2'd2) begin
                    state_d = ST_PL_WAIT;
                    tmr_val = CW'(PLD_CYC - 1);
                end else begin
                    state_d = ST_SETUP;
                    step_d  = step_q + 2'd1;
                    tmr_val = CW'(SU_CYC - 1);
                end
            end
            ST_PL_WAIT: if (tmr_zero) begin
                state_d  = ST_PL_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CW'(PLW_CYC - 1);
            end
            ST_PL_HIGH: if (tmr_zero) begin
                state_d = ST_IDLE;
            end
            ST_OE_LO: if (tmr_zero) begin
                cap_lo   = 1'b1;
                state_d  = ST_OE_HI;
                tmr_load = 1'b1;
                tmr_val  = CW'(DV_CYC - 1);
            end
            ST_OE_HI: if (tmr_zero) begin
                cap_hi   = 1'b1;
                state_d  = ST_RELEASE;
                tmr_load = 1'b1;
                tmr_val  = CW'(RZ_CYC - 1);
            end
            ST_RELEASE: if (tmr_zero) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state and byte step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Command fields held for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            rd_q    <= cmd_rd;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
        end
    end

    pprog_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pprog_lane u_lane (
        .state   (state_q),
        .step    (step_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .strobe  (tgt_strobe),
        .act     (tgt_act),
        .bsel    (tgt_bsel),
        .latch   (tgt_latch),
        .oe_n    (tgt_oe_n),
        .dout    (tgt_dout),
        .dout_en (tgt_dout_en)
    );

    pprog_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi),
        .din    (tgt_din),
        .word   (rd_data)
    );
endmodule

// File: rtl/pprog_seq_chk.sv
// Checker for pprog_seq: pin-level timing and handshake properties.
// Assumes the same clock-period and timing parameters as the design.
module pprog_seq_chk
    import pprog_pkg::*;
#(
    parameter int unsigned CLK_PS    = 5000,
    parameter int unsigned T_HIGH_NS = 150,
    parameter int unsigned T_LOW_NS  = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic       busy,
    input logic       rd_valid,
    input logic       tgt_strobe,
    input logic [1:0] tgt_act,
    input logic       tgt_bsel,
    input logic       tgt_latch,
    input logic       tgt_oe_n,
    input logic [7:0] tgt_dout,
    input logic       tgt_dout_en
);
    localparam int unsigned HI_MIN = ns_to_cyc(T_HIGH_NS, CLK_PS);
    localparam int unsigned LO_MIN = ns_to_cyc(T_LOW_NS, CLK_PS);

    logic [15:0] hi_len;
    logic [15:0] lo_len;

    // Measure the current high and low run of the strobe (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
            lo_len <= 16'(LO_MIN);
        end else if (tgt_strobe) begin
            lo_len <= '0;
            if (hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
            if (lo_len != 16'hFFFF) lo_len <= lo_len + 1'b1;
        end
    end

    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_oe_n |-> !tgt_dout_en);

    a_r1_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_strobe && $past(tgt_strobe) |-> $stable(tgt_act) && $stable(tgt_dout) && $stable(tgt_bsel));

    a_r3_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_strobe) |-> hi_len >= 16'(HI_MIN));

    a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_strobe) |-> lo_len >= 16'(LO_MIN));

    a_r4_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_latch |-> !tgt_strobe && busy && tgt_oe_n);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind pprog_seq pprog_seq_chk #(
    .CLK_PS    (CLK_PS),
    .T_HIGH_NS (T_HIGH_NS),
    .T_LOW_NS  (T_LOW_NS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .tgt_strobe  (tgt_strobe),
    .tgt_act     (tgt_act),
    .tgt_bsel    (tgt_bsel),
    .tgt_latch   (tgt_latch),
    .tgt_oe_n    (tgt_oe_n),
    .tgt_dout    (tgt_dout),
    .tgt_dout_en (tgt_dout_en)
);

// File: tb/pprog_seq_bench.sv
// Bench: a behavioural queue of expected pin states per cycle, compared on every clock.
module pprog_seq_bench;
    localparam int PS = 5000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + PS - 1) / PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int HO  = (0 * 1000 + PS - 1) / PS < 1 ? 1 : (0 * 1000 + PS - 1) / PS;
    int su, hi, lh, pld, plw, dv, rz;

    typedef struct packed {
        logic        busy;
        logic        stb;
        logic [1:0]  act;
        logic        bs;
        logic        pl;
        logic        oen;
        logic        en;
        logic [7:0]  d;
        logic        rv;
        logic [15:0] rw;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_rd;
    logic [7:0]  cmd_addr;
    logic [15:0] cmd_wdata;
    logic        cmd_ready, busy, rd_valid;
    logic [15:0] rd_data;
    logic        tgt_strobe, tgt_bsel, tgt_latch, tgt_oe_n, tgt_dout_en;
    logic [1:0]  tgt_act;
    logic [7:0]  tgt_dout, tgt_din;
    logic [7:0]  taddr = 8'h00;

    int   n_chk = 0;
    int   n_err = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pprog_seq u_pprog_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .tgt_strobe(tgt_strobe),
        .tgt_act(tgt_act), .tgt_bsel(tgt_bsel), .tgt_latch(tgt_latch),
        .tgt_oe_n(tgt_oe_n), .tgt_dout(tgt_dout), .tgt_dout_en(tgt_dout_en),
        .tgt_din(tgt_din)
    );

    // Target model: a word per address, address taken on the strobe fall.
    function automatic logic [7:0] t_lo(input logic [7:0] a);
        return a ^ 8'hA5;
    endfunction
    function automatic logic [7:0] t_hi(input logic [7:0] a);
        return {a[3:0], a[7:4]} + 8'h3C;
    endfunction
    always @(negedge tgt_strobe) if (tgt_act == 2'b00) taddr <= tgt_dout;
    assign tgt_din = tgt_oe_n ? 8'h00 : (tgt_bsel ? t_hi(taddr) : t_lo(taddr));

    task automatic chk(input logic ok, input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act_v, exp_v);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e = '0;
        e.oen = 1'b1;
        return e;
    endfunction

    function automatic void push_n(input int n, input exp_t e);
        for (int i = 0; i < n; i++) q.push_back(e);
    endfunction

    // Build the expected trace of one accepted command.
    function automatic void build(input logic rd, input logic [7:0] a, input logic [15:0] d);
        exp_t e;
        logic [7:0] bytes [3];
        bytes[0] = a; bytes[1] = d[7:0]; bytes[2] = d[15:8];
        for (int s = 0; s < (rd ? 1 : 3); s++) begin
            e = idle_e();
            e.busy = 1'b1; e.en = 1'b1; e.d = bytes[s];
            e.act = (s == 0) ? 2'b00 : 2'b01;
            e.bs = (s == 2);
            push_n(su, e);
            e.stb = 1'b1; push_n(hi, e);
            e.stb = 1'b0; push_n(HO, e);
        end
        if (!rd) begin
            push_n(pld, e);
            e.pl = 1'b1; push_n(plw, e);
        end else begin
            e = idle_e();
            e.busy = 1'b1; e.oen = 1'b0;
            push_n(dv, e);
            e.bs = 1'b1; push_n(dv, e);
            e.bs = 1'b0; e.oen = 1'b1;
            push_n(rz - 1, e);
            e.rv = 1'b1; e.rw = {t_hi(a), t_lo(a)};
            push_n(1, e);
        end
    endfunction

    // Per-clock comparison against the model, then model acceptance.
    always @(negedge clk) begin
        exp_t e;
        logic mready;
        if (rst_n === 1'b1) begin
            mready = (q.size() == 0);
            e = mready ? idle_e() : q.pop_front();
            chk(cmd_ready == mready, "R8 ready", 32'(cmd_ready), 32'(mready));
            chk(busy == e.busy, "R8 busy", 32'(busy), 32'(e.busy));
            chk(tgt_strobe == e.stb, "R3 R10 strobe", 32'(tgt_strobe), 32'(e.stb));
            chk(tgt_act == e.act, "R1 action", 32'(tgt_act), 32'(e.act));
            chk(tgt_bsel == e.bs, "R2 byte select", 32'(tgt_bsel), 32'(e.bs));
            chk(tgt_latch == e.pl, "R4 page latch", 32'(tgt_latch), 32'(e.pl));
            chk(tgt_oe_n == e.oen, "R5 output enable", 32'(tgt_oe_n), 32'(e.oen));
            chk(tgt_dout_en == e.en, "R6 drive enable", 32'(tgt_dout_en), 32'(e.en));
            if (e.en) chk(tgt_dout == e.d, "R1 bus byte", 32'(tgt_dout), 32'(e.d));
            chk(rd_valid == e.rv, "R7 rd_valid", 32'(rd_valid), 32'(e.rv));
            if (e.rv) chk(rd_data == e.rw, "R7 rd_data", 32'(rd_data), 32'(e.rw));
            if (mready && cmd_valid) build(cmd_rd, cmd_addr, cmd_wdata);
        end
    end

    // Offer a command until taken; optionally keep offering junk while busy (R8).
    task automatic issue(input logic rd, input logic [7:0] a, input logic [15:0] d, input int junk);
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_rd = rd; cmd_addr = a; cmd_wdata = d;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        if (junk > 0) begin
            cmd_rd = ~rd; cmd_addr = ~a; cmd_wdata = ~d;
            repeat (junk) @(posedge clk);
            #1;
        end
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        su  = cyc(67) > (cyc(200) - HO) ? cyc(67) : cyc(200) - HO;
        hi  = cyc(150); lh = cyc(200);
        pld = cyc(67);  plw = cyc(150);
        dv  = cyc(250); rz = cyc(250);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_rd = 1'b0; cmd_addr = '0; cmd_wdata = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset levels
        chk(!tgt_strobe && !tgt_latch && tgt_oe_n && !tgt_dout_en && tgt_act == 2'b00,
            "R9 reset pins", {27'd0, tgt_strobe, tgt_latch, tgt_oe_n, tgt_dout_en, 1'b0}, 32'h4);
        chk(!busy && !rd_valid && cmd_ready, "R9 reset status", {30'd0, busy, rd_valid}, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        issue(1'b0, 8'h12, 16'hBEEF, 0);   // R1 R4 basic load
        issue(1'b1, 8'h12, 16'h0000, 0);   // R5 R7 basic read
        issue(1'b0, 8'h00, 16'hFFFF, 20);  // R8 junk while busy
        issue(1'b1, 8'hFF, 16'h0000, 20);  // R8 junk during read
        issue(1'b0, 8'hFF, 16'h0000, 0);
        issue(1'b1, 8'h00, 16'h0000, 0);   // R7 back-to-back
        issue(1'b0, 8'h5A, 16'h1234, 0);
        issue(1'b1, 8'hC3, 16'h0000, 0);
        wait (q.size() == 0);
        repeat (10) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule